// File: doc/BRIEF.md
# Superpage Region Hint Table

This block guesses, from a virtual address alone, whether the access lands in a 2 MB superpage. The guess comes back in the same cycle as the lookup, so a cache with set-partitioned ways can use it to choose between a narrow superpage probe and a wide base-page probe before translation finishes.

The table is direct-mapped and keeps only region tags. A 2 MB region is VA[63:21]. The low bits of the region number select the entry, and the remaining upper bits form the stored tag. The table says "superpage" only when the selected entry is valid and its tag matches.

The table is kept in step with the L1 TLB through three update ports:
- a fill port, used when a 2 MB translation enters the TLB;
- an invalidate port, used when such a translation leaves the TLB;
- a correction port, used when translation reveals the true page size.

Capacity conflicts can evict a live region. This gives a false negative, whose only cost is a wider probe.

Top module: `sp_hint_table`

## Requirements
- R1: After the asynchronous active-low reset, every entry is invalid, so every lookup reports 0 until a region is written.
- R2: lookup_sp_o is 1 exactly when the entry indexed by lookup_va_i[21+IDX_W-1:21] is valid and holds tag lookup_va_i[VA_W-1:21+IDX_W]. It is combinational from the lookup address and the current table contents.
- R3: A fill writes its region into the indexed entry, and the region hits from the next cycle on. A fill to an entry holding a different region replaces that region, so the old region misses afterwards.
- R4: An invalidate clears the indexed entry only when that entry holds the invalidated region. An invalidate for a region the entry does not hold leaves the entry unchanged.
- R5: A correction with mispred_is_sp_i = 1 installs the reported region, just as a fill does.
- R6: A correction with mispred_is_sp_i = 0 clears the indexed entry if it holds the reported region. Otherwise it changes nothing.
- R7: A lookup in the same cycle as a write to its entry returns the contents from before that write. The write is seen from the next cycle.
- R8: When several update events reach one entry in the same cycle, they take effect in this order: fill first, then correction, then invalidate. The later event acts on the result of the earlier one.
- R9: Address bits below bit 21 affect neither the index nor the tag, so every address in one 2 MB region gets the same prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_va_i | input | VA_W | Address being predicted |
| lookup_sp_o | output | 1 | 1 = predicted superpage |
| fill_valid_i | input | 1 | A 2 MB translation was filled into the TLB |
| fill_va_i | input | VA_W | Address inside the filled region |
| inval_valid_i | input | 1 | A 2 MB translation was invalidated |
| inval_va_i | input | VA_W | Address inside the invalidated region |
| mispred_valid_i | input | 1 | A prediction was found wrong after translation |
| mispred_va_i | input | VA_W | Address of the mispredicted access |
| mispred_is_sp_i | input | 1 | True page size: 1 = superpage, 0 = base page |

## Verification
The lookup result is due in the same cycle as its address. Each update becomes visible one clock edge after it is presented.

The bench drives all inputs on the falling edge and samples lookup_sp_o 1 ns later. At that point the result must still reflect the table as it stood before the pending update. The bench then advances its reference table by that update, so it is ready for the comparison in the following cycle.

Random traffic is confined to a few tags and indices, which forces collisions, same-entry event combinations, and invalidates or corrections that do not match. Directed sequences cover reset, eviction, the same-cycle ordering, and changes to the in-page address bits.

// File: rtl/sp_hint_pkg.sv
package sp_hint_pkg;
  // per-entry update selects, already decoded against the entry index
  typedef struct packed {
    logic fill;
    logic mp;
    logic mp_sp;
    logic inv;
  } sp_evt_t;
endpackage

// File: rtl/sp_addr_split.sv
module sp_addr_split #(
  parameter int unsigned VA_W       = 64,
  parameter int unsigned REGION_LSB = 21,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned TAG_W      = VA_W - REGION_LSB - IDX_W
) (
  input  logic [VA_W-1:0]  va_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  assign idx_o = va_i[REGION_LSB +: IDX_W];
  assign tag_o = va_i[VA_W-1 -: TAG_W];
endmodule

// File: rtl/sp_entry.sv
module sp_entry
  import sp_hint_pkg::*;
#(
  parameter int unsigned TAG_W = 39
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sp_evt_t          evt_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic [TAG_W-1:0] mp_tag_i,
  input  logic [TAG_W-1:0] inv_tag_i,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             v_q, v_d;
  logic [TAG_W-1:0] t_q, t_d;

  // ordered: fill, then correction, then invalidate
  always_comb begin
    v_d = v_q;
    t_d = t_q;
    if (evt_i.fill) begin
      v_d = 1'b1;
      t_d = fill_tag_i;
    end
    if (evt_i.mp) begin
      if (evt_i.mp_sp) begin
        v_d = 1'b1;
        t_d = mp_tag_i;
      end else if (v_d && t_d == mp_tag_i) begin
        v_d = 1'b0;
      end
    end
    if (evt_i.inv && v_d && t_d == inv_tag_i) v_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= 1'b0;
      t_q <= '0;
    end else begin
      v_q <= v_d;
      t_q <= t_d;
    end
  end

  assign valid_o = v_q;
  assign tag_o   = t_q;
endmodule

// File: rtl/sp_hint_table.sv
module sp_hint_table
  import sp_hint_pkg::*;
#(
  parameter int unsigned VA_W       = 64,
  parameter int unsigned REGION_LSB = 21,
  parameter int unsigned ENTRIES    = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [VA_W-1:0] lookup_va_i,
  output logic            lookup_sp_o,
  input  logic            fill_valid_i,
  input  logic [VA_W-1:0] fill_va_i,
  input  logic            inval_valid_i,
  input  logic [VA_W-1:0] inval_va_i,
  input  logic            mispred_valid_i,
  input  logic [VA_W-1:0] mispred_va_i,
  input  logic            mispred_is_sp_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = VA_W - REGION_LSB - IDX_W;

  logic [IDX_W-1:0] lk_idx, fl_idx, mp_idx, iv_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag, mp_tag, iv_tag;

  sp_addr_split #(.VA_W(VA_W), .REGION_LSB(REGION_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_split_lk (.va_i(lookup_va_i),  .idx_o(lk_idx), .tag_o(lk_tag));
  sp_addr_split #(.VA_W(VA_W), .REGION_LSB(REGION_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_split_fl (.va_i(fill_va_i),    .idx_o(fl_idx), .tag_o(fl_tag));
  sp_addr_split #(.VA_W(VA_W), .REGION_LSB(REGION_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_split_mp (.va_i(mispred_va_i), .idx_o(mp_idx), .tag_o(mp_tag));
  sp_addr_split #(.VA_W(VA_W), .REGION_LSB(REGION_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W))
    u_split_iv (.va_i(inval_va_i),   .idx_o(iv_idx), .tag_o(iv_tag));

  logic [ENTRIES-1:0] ent_v;
  logic [TAG_W-1:0]   ent_t [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    sp_evt_t evt;
    assign evt.fill  = fill_valid_i    && (fl_idx == IDX_W'(g));
    assign evt.mp    = mispred_valid_i && (mp_idx == IDX_W'(g));
    assign evt.mp_sp = mispred_is_sp_i;
    assign evt.inv   = inval_valid_i   && (iv_idx == IDX_W'(g));

    sp_entry #(.TAG_W(TAG_W)) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt),
      .fill_tag_i (fl_tag),
      .mp_tag_i   (mp_tag),
      .inv_tag_i  (iv_tag),
      .valid_o    (ent_v[g]),
      .tag_o      (ent_t[g])
    );
  end

  assign lookup_sp_o = ent_v[lk_idx] && (ent_t[lk_idx] == lk_tag);
endmodule

// File: rtl/sp_hint_table_chk.sv
module sp_hint_table_chk #(
  parameter int unsigned VA_W       = 64,
  parameter int unsigned REGION_LSB = 21
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [VA_W-1:0] lookup_va_i,
  input logic            lookup_sp_o,
  input logic            fill_valid_i,
  input logic [VA_W-1:0] fill_va_i,
  input logic            inval_valid_i,
  input logic [VA_W-1:0] inval_va_i,
  input logic            mispred_valid_i,
  input logic [VA_W-1:0] mispred_va_i,
  input logic            mispred_is_sp_i
);
  localparam int unsigned RG_W = VA_W - REGION_LSB;

  logic [RG_W-1:0] lk_rg, fl_rg, iv_rg, mp_rg;
  assign lk_rg = lookup_va_i[VA_W-1:REGION_LSB];
  assign fl_rg = fill_va_i[VA_W-1:REGION_LSB];
  assign iv_rg = inval_va_i[VA_W-1:REGION_LSB];
  assign mp_rg = mispred_va_i[VA_W-1:REGION_LSB];

  logic any_set_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_set_q <= 1'b0;
    else if (fill_valid_i || (mispred_valid_i && mispred_is_sp_i)) any_set_q <= 1'b1;
  end

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_set_q |-> !lookup_sp_o); // R1

  AST_LOOKUP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fill_valid_i && !inval_valid_i && !mispred_valid_i)
    |=> (!$stable(lookup_va_i) || $stable(lookup_sp_o))); // R2

  AST_FILL_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !inval_valid_i && !mispred_valid_i)
    |=> (lk_rg != $past(fl_rg) || lookup_sp_o)); // R3

  AST_INVAL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_valid_i && !fill_valid_i && !mispred_valid_i)
    |=> (lk_rg != $past(iv_rg) || !lookup_sp_o)); // R4

  AST_MP_INSTALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mispred_valid_i && mispred_is_sp_i && !inval_valid_i)
    |=> (lk_rg != $past(mp_rg) || lookup_sp_o)); // R5

  AST_MP_REMOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mispred_valid_i && !mispred_is_sp_i)
    |=> (lk_rg != $past(mp_rg) || !lookup_sp_o)); // R6
endmodule

bind sp_hint_table sp_hint_table_chk #(.VA_W(VA_W), .REGION_LSB(REGION_LSB)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .lookup_va_i     (lookup_va_i),
  .lookup_sp_o     (lookup_sp_o),
  .fill_valid_i    (fill_valid_i),
  .fill_va_i       (fill_va_i),
  .inval_valid_i   (inval_valid_i),
  .inval_va_i      (inval_va_i),
  .mispred_valid_i (mispred_valid_i),
  .mispred_va_i    (mispred_va_i),
  .mispred_is_sp_i (mispred_is_sp_i)
);

// File: tb/sp_hint_table_bench.sv
`timescale 1ns/1ps
module sp_hint_table_bench;
  localparam int unsigned VA_W  = 64;
  localparam int unsigned RLSB  = 21;
  localparam int unsigned NENT  = 16;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned TAG_W = VA_W - RLSB - IDX_W;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [VA_W-1:0] lookup_va = '0, fill_va = '0, inval_va = '0, mp_va = '0;
  logic            lookup_sp;
  logic            fill_v = 1'b0, inval_v = 1'b0, mp_v = 1'b0, mp_sp = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sp_hint_table #(.VA_W(VA_W), .REGION_LSB(RLSB), .ENTRIES(NENT)) u_sp_hint_table (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .lookup_va_i     (lookup_va),
    .lookup_sp_o     (lookup_sp),
    .fill_valid_i    (fill_v),
    .fill_va_i       (fill_va),
    .inval_valid_i   (inval_v),
    .inval_va_i      (inval_va),
    .mispred_valid_i (mp_v),
    .mispred_va_i    (mp_va),
    .mispred_is_sp_i (mp_sp)
  );

  // reference table
  bit               mdl_v [NENT];
  logic [TAG_W-1:0] mdl_t [NENT];

  function automatic int b_idx(input logic [VA_W-1:0] va);
    return int'(va[RLSB +: IDX_W]);
  endfunction
  function automatic logic [TAG_W-1:0] b_tag(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: TAG_W];
  endfunction
  function automatic logic [VA_W-1:0] mk_va(input int tag, input int idx, input int low);
    return {TAG_W'(tag), IDX_W'(idx), RLSB'(low)};
  endfunction
  function automatic bit exp_hit(input logic [VA_W-1:0] va);
    return mdl_v[b_idx(va)] && mdl_t[b_idx(va)] == b_tag(va);
  endfunction

  task automatic mdl_clear();
    for (int i = 0; i < NENT; i++) begin mdl_v[i] = 1'b0; mdl_t[i] = '0; end
  endtask

  task automatic mdl_step();
    int i;
    if (fill_v) begin i = b_idx(fill_va); mdl_v[i] = 1'b1; mdl_t[i] = b_tag(fill_va); end
    if (mp_v) begin
      i = b_idx(mp_va);
      if (mp_sp) begin mdl_v[i] = 1'b1; mdl_t[i] = b_tag(mp_va); end
      else if (mdl_v[i] && mdl_t[i] == b_tag(mp_va)) mdl_v[i] = 1'b0;
    end
    if (inval_v) begin
      i = b_idx(inval_va);
      if (mdl_v[i] && mdl_t[i] == b_tag(inval_va)) mdl_v[i] = 1'b0;
    end
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: lookup_sp_o=%0b expected %0b (va=%h)", req, act, exp, lookup_va);
    end
  endtask

  // drive at falling edge, sample 1 ns later, then advance model to post-edge state
  task automatic cyc(input bit fe, input logic [VA_W-1:0] fv,
                     input bit me, input logic [VA_W-1:0] mv, input bit ms,
                     input bit ie, input logic [VA_W-1:0] iv,
                     input logic [VA_W-1:0] lv, input string req);
    @(negedge clk);
    fill_v = fe; fill_va = fv; mp_v = me; mp_va = mv; mp_sp = ms;
    inval_v = ie; inval_va = iv; lookup_va = lv;
    #1;
    check(req, lookup_sp, exp_hit(lv));
    mdl_step();
  endtask

  task automatic look(input logic [VA_W-1:0] lv, input string req);
    cyc(0, '0, 0, '0, 0, 0, '0, lv, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; fill_v = 0; mp_v = 0; inval_v = 0;
    mdl_clear();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [VA_W-1:0] a, b, c, a2;
    void'($urandom(32'h5eed_0f1a));
    a  = mk_va(5, 3, 21'h00123);
    a2 = mk_va(5, 3, 21'h1ff000);
    b  = mk_va(9, 3, 21'h00040);
    c  = mk_va(2, 7, 21'h0);
    mdl_clear();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    look(a, "R1");
    if (lookup_sp !== 1'b0) begin n_fail++; $display("FAIL R1: act=%0b exp=0", lookup_sp); end
    n_chk++;
    cyc(1, a, 0, '0, 0, 0, '0, a, "R7");        // same-cycle write: old contents
    look(a, "R3");
    look(a2, "R9");
    cyc(1, b, 0, '0, 0, 0, '0, a, "R7");        // still hits a this cycle
    look(a, "R3");                              // evicted
    look(b, "R3");
    cyc(0, '0, 0, '0, 0, 1, a, b, "R4");        // non-matching invalidate
    look(b, "R4");
    cyc(0, '0, 0, '0, 0, 1, b, b, "R4");
    look(b, "R4");
    cyc(0, '0, 1, a, 1, 0, '0, a, "R5");
    look(a, "R5");
    cyc(0, '0, 1, b, 0, 0, '0, a, "R6");        // non-matching correction
    look(a, "R6");
    cyc(0, '0, 1, a, 0, 0, '0, a, "R6");
    look(a, "R6");
    cyc(1, a, 0, '0, 0, 1, a, a, "R8");         // fill then invalidate -> empty
    look(a, "R8");
    cyc(1, a, 1, a, 0, 0, '0, a, "R8");         // fill then correction-clear -> empty
    look(a, "R8");
    cyc(1, b, 1, a, 1, 1, b, a, "R8");          // correction-set overrides fill; inval b misses
    look(a, "R8");
    look(b, "R8");
    cyc(1, c, 0, '0, 0, 0, '0, c, "R3");
    look(c, "R3");
    do_reset();
    look(c, "R1");
    look(a, "R1");

    // random traffic over a small region pool
    for (int n = 0; n < 4000; n++) begin
      logic [VA_W-1:0] fv, mv, iv, lv;
      fv = mk_va(int'($urandom % 3), int'($urandom % 4), int'($urandom));
      mv = mk_va(int'($urandom % 3), int'($urandom % 4), int'($urandom));
      iv = mk_va(int'($urandom % 3), int'($urandom % 4), int'($urandom));
      lv = mk_va(int'($urandom % 3), int'($urandom % 4), int'($urandom));
      cyc(($urandom % 3) == 0, fv, ($urandom % 4) == 0, mv, $urandom % 2,
          ($urandom % 4) == 0, iv, lv, "R2");
    end

    look(a, "R2");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule